// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block collects eight level-sensitive interrupt requests and reports them to a processor only through polling. Software writes command words through a two-address port (selected by `a0_i`) and reads back a poll result, the pending-request register, the in-service register or the mask register over an 8-bit data path. Nothing is ever pushed to the processor: a poll command arms the next low-address read, and that read both returns the winning line and marks it as in service.

Priority is resolved among requests that are latched, unmasked and not blocked by work already in service. The order is circular: a three-bit "bottom" line holds the lowest priority and the line after it the highest. Software can move the bottom explicitly or as a side effect of ending service on a line. A special mask mode lets lower-priority requests through while higher ones are still in service.

Top module: `pic_poll_ctrl`

## Requirements
- R1: After reset the mask, in-service and pending registers read as zero, a low-address read returns the pending register, special mask mode is off, and line 0 has the highest priority with line 7 lowest.
- R2: A high level on a request input is latched into the pending register at the next clock edge and stays there after the input falls; a write at `a0_i`=0 with bits 4:3=01, bit 2=0 and bits 1:0=10 selects the pending register for low-address reads, bits 1:0=11 selects the in-service register.
- R3: A write at `a0_i`=1 outside initialization loads the mask register; a read at `a0_i`=1 returns it.
- R4: A write at `a0_i`=0 with bit 4=1 starts initialization: it clears mask, in-service and pending registers, turns off special mask mode, selects the pending register for reads and restores line 0 highest / line 7 lowest; the next write at `a0_i`=1 is consumed as the second initialization word and leaves the mask unchanged.
- R5: A write at `a0_i`=0 with bits 4:3=01 and bit 2=1 arms a poll; the next read at `a0_i`=0 returns bit 7=1 and the line number in bits 2:0 (bits 6:3 zero) for the highest-priority eligible request, sets that line's in-service bit, clears its pending bit and disarms the poll. Masked lines are never eligible.
- R6: Outside special mask mode, a request is not reported while an in-service bit of equal or higher priority is set.
- R7: A write at `a0_i`=0 with bits 4:3=01 and bits 6:5=11 enters special mask mode, bits 6:5=10 leaves it; in that mode in-service lines neither block other requests nor are themselves eligible.
- R8: A write at `a0_i`=0 with bits 4:3=00 and bits 7:5=001 clears the highest-priority in-service bit; bits 7:5=011 clears the in-service bit of the line in bits 2:0.
- R9: Bits 7:5=101 clears the highest-priority in-service bit and makes that line lowest priority; 111 clears line bits 2:0 and makes it lowest; 110 makes line bits 2:0 lowest without touching the in-service register.
- R10: A poll read with no eligible request returns 0x00 and changes neither the in-service nor the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 8 | Level-sensitive interrupt requests, line 0 at bit 0 |
| a0_i | input | 1 | Port address select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current `a0_i` and state |

## Verification
The assertions assume the processor never raises the read and write strobes in the same cycle, so a poll-taking read can never coincide with an end-of-service or initialization command; the stimulus issues each access as a separate single-cycle strobe with idle gaps. They also take for granted that each strobe covers one access only, which the bench respects by dropping the strobe at the next falling edge. Request inputs change only away from the clock edge and are held for at least one full cycle so the latch behaviour is deterministic.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    OP2_NOP0     = 3'b000,
    OP2_EOI_NS   = 3'b001,
    OP2_NOP2     = 3'b010,
    OP2_EOI_SP   = 3'b011,
    OP2_NOP4     = 3'b100,
    OP2_ROT_NS   = 3'b101,
    OP2_SET_PRIO = 3'b110,
    OP2_ROT_SP   = 3'b111
  } ocw2_op_e;

  typedef struct packed {
    logic init;
    logic icw2;
    logic mask_ld;
    logic eoi_ns;
    logic eoi_sp;
    logic rot;
    logic set_prio;
    logic poll;
    logic sel_ld;
    logic sel_isr;
    logic smm_ld;
    logic smm_val;
  } pic_cmd_t;

endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              init2_i,
  output pic_cmd_t          cmd_o
);

  ocw2_op_e op;
  assign op = ocw2_op_e'(wdata_i[7:5]);

  always_comb begin
    cmd_o = '0;
    if (wr_i) begin
      if (a0_i) begin
        if (init2_i) cmd_o.icw2    = 1'b1;
        else         cmd_o.mask_ld = 1'b1;
      end else if (wdata_i[4]) begin
        cmd_o.init = 1'b1;
      end else if (!wdata_i[3]) begin
        unique case (op)
          OP2_EOI_NS:   cmd_o.eoi_ns = 1'b1;
          OP2_EOI_SP:   cmd_o.eoi_sp = 1'b1;
          OP2_ROT_NS:   begin cmd_o.eoi_ns = 1'b1; cmd_o.rot = 1'b1; end
          OP2_ROT_SP:   begin cmd_o.eoi_sp = 1'b1; cmd_o.rot = 1'b1; end
          OP2_SET_PRIO: cmd_o.set_prio = 1'b1;
          default:      ;
        endcase
      end else begin
        cmd_o.poll    = wdata_i[2];
        cmd_o.sel_ld  = !wdata_i[2] && wdata_i[1];
        cmd_o.sel_isr = wdata_i[0];
        cmd_o.smm_ld  = wdata_i[6];
        cmd_o.smm_val = wdata_i[5];
      end
    end
  end

endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
  parameter  int unsigned NUM_IRQ = 8,
  localparam int unsigned LW      = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  input  logic [LW-1:0]      bot_i,
  output logic               found_o,
  output logic [LW-1:0]      code_o,
  output logic [LW-1:0]      rank_o
);

  logic [LW-1:0] idx;

  // rank 0 is the line right after the bottom line
  always_comb begin
    found_o = 1'b0;
    code_o  = '0;
    rank_o  = '0;
    idx     = '0;
    for (int r = NUM_IRQ - 1; r >= 0; r--) begin
      idx = bot_i + LW'(1) + LW'(r);
      if (vec_i[idx]) begin
        found_o = 1'b1;
        code_o  = idx;
        rank_o  = LW'(r);
      end
    end
  end

endmodule

// File: rtl/pic_poll_ctrl.sv
module pic_poll_ctrl
  import pic_pkg::*;
#(
  parameter  int unsigned NUM_IRQ = 8,
  parameter  int unsigned DATA_W  = 8,
  localparam int unsigned LW      = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               a0_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o
);

  logic [NUM_IRQ-1:0] irr_q, irr_d, isr_q, isr_d, imr_q, imr_d;
  logic [LW-1:0]      bot_q, bot_d;
  logic               smm_q, smm_d, sel_isr_q, sel_isr_d;
  logic               poll_q, poll_d, init2_q, init2_d;

  pic_cmd_t           cmd;
  logic [LW-1:0]      lvl;
  logic [NUM_IRQ-1:0] cand;
  logic               req_found, isr_found, poll_hit, take, eoi_en;
  logic [LW-1:0]      req_code, req_rank, isr_code, isr_rank, eoi_line;
  logic [NUM_IRQ-1:0] take_oh, eoi_oh;

  assign lvl = wdata_i[LW-1:0];

  pic_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .wr_i    (wr_i),
    .a0_i    (a0_i),
    .wdata_i (wdata_i),
    .init2_i (init2_q),
    .cmd_o   (cmd)
  );

  assign cand = irr_q & ~imr_q & (smm_q ? ~isr_q : {NUM_IRQ{1'b1}});

  pic_prio_res #(.NUM_IRQ(NUM_IRQ)) u_req_res (
    .vec_i   (cand),
    .bot_i   (bot_q),
    .found_o (req_found),
    .code_o  (req_code),
    .rank_o  (req_rank)
  );

  pic_prio_res #(.NUM_IRQ(NUM_IRQ)) u_isr_res (
    .vec_i   (isr_q),
    .bot_i   (bot_q),
    .found_o (isr_found),
    .code_o  (isr_code),
    .rank_o  (isr_rank)
  );

  assign poll_hit = req_found && (smm_q || !isr_found || (req_rank < isr_rank));
  assign take     = rd_i && !wr_i && !a0_i && poll_q && poll_hit;
  assign take_oh  = take ? (NUM_IRQ'(1) << req_code) : '0;

  assign eoi_en   = cmd.eoi_sp || (cmd.eoi_ns && isr_found);
  assign eoi_line = cmd.eoi_sp ? lvl : isr_code;
  assign eoi_oh   = eoi_en ? (NUM_IRQ'(1) << eoi_line) : '0;

  always_comb begin
    irr_d     = (irr_q | irq_req_i) & ~take_oh;
    isr_d     = (isr_q & ~eoi_oh) | take_oh;
    imr_d     = cmd.mask_ld ? wdata_i[NUM_IRQ-1:0] : imr_q;
    bot_d     = bot_q;
    smm_d     = cmd.smm_ld ? cmd.smm_val : smm_q;
    sel_isr_d = cmd.sel_ld ? cmd.sel_isr : sel_isr_q;
    poll_d    = poll_q;
    init2_d   = cmd.icw2 ? 1'b0 : init2_q;
    if (rd_i && !a0_i) poll_d = 1'b0;
    if (cmd.poll)      poll_d = 1'b1;
    if (cmd.rot && eoi_en) bot_d = eoi_line;
    if (cmd.set_prio)      bot_d = lvl;
    if (cmd.init) begin
      irr_d     = '0;
      isr_d     = '0;
      imr_d     = '0;
      bot_d     = '1;
      smm_d     = 1'b0;
      sel_isr_d = 1'b0;
      poll_d    = 1'b0;
      init2_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      bot_q     <= '1;
      smm_q     <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      init2_q   <= 1'b0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      imr_q     <= imr_d;
      bot_q     <= bot_d;
      smm_q     <= smm_d;
      sel_isr_q <= sel_isr_d;
      poll_q    <= poll_d;
      init2_q   <= init2_d;
    end
  end

  always_comb begin
    if (a0_i) begin
      rdata_o = DATA_W'(imr_q);
    end else if (poll_q) begin
      rdata_o      = '0;
      rdata_o[7]   = poll_hit;
      rdata_o[LW-1:0] = poll_hit ? req_code : '0;
    end else begin
      rdata_o = sel_isr_q ? DATA_W'(isr_q) : DATA_W'(irr_q);
    end
  end

endmodule

// File: rtl/pic_poll_ctrl_chk.sv
module pic_poll_ctrl_chk #(
  parameter  int unsigned NUM_IRQ = 8,
  parameter  int unsigned DATA_W  = 8,
  localparam int unsigned LW      = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               a0_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_IRQ-1:0] isr_q,
  input logic [NUM_IRQ-1:0] imr_q,
  input logic [LW-1:0]      bot_q,
  input logic               smm_q,
  input logic               poll_q,
  input logic               init2_q
);

  p_rd_wr_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  p_mask_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && a0_i && !init2_q) |=> (imr_q == $past(wdata_i[NUM_IRQ-1:0])));

  p_init_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a0_i && wdata_i[4]) |=>
      (imr_q == '0 && isr_q == '0 && !smm_q && bot_q == '1 && init2_q));

  p_icw2_keeps_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && a0_i && init2_q) |=> ($stable(imr_q) && !init2_q));

  p_single_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  p_poll_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !a0_i && poll_q) |=> !poll_q);

  p_poll_format_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !a0_i && poll_q) |-> (rdata_o[6:3] == 4'b0000));

  p_smm_enter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a0_i && wdata_i[4:3] == 2'b01 && wdata_i[6:5] == 2'b11) |=> smm_q);

  p_spec_eoi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a0_i && wdata_i[4:3] == 2'b00 && wdata_i[6:5] == 2'b11)
      |=> !isr_q[$past(wdata_i[LW-1:0])]);

  p_set_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !a0_i && wdata_i[7:3] == 5'b11000) |=> (bot_q == $past(wdata_i[LW-1:0])));

endmodule

bind pic_poll_ctrl pic_poll_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a0_i    (a0_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .isr_q   (isr_q),
  .imr_q   (imr_q),
  .bot_q   (bot_q),
  .smm_q   (smm_q),
  .poll_q  (poll_q),
  .init2_q (init2_q)
);

// File: tb/pic_poll_ctrl_tb_top.sv
module pic_poll_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       a0 = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_poll_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req),
    .a0_i(a0), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // ---------------- behavioural reference ----------------
  int m_irr, m_isr, m_imr, m_bot, m_smm, m_sel, m_poll, m_init2;

  function automatic int rank_of(int line, int bot);
    return (line - bot - 1 + 2*N) % N;
  endfunction

  function automatic int best(int vec, int bot);
    int w = -1;
    for (int r = 0; r < N; r++) begin
      int ln = (bot + 1 + r) % N;
      if (w < 0 && vec[ln]) w = ln;
    end
    return w;
  endfunction

  function automatic int poll_winner();
    int cand, w, h;
    cand = m_irr & ~m_imr & (m_smm != 0 ? ~m_isr : 'hFF) & 'hFF;
    w = best(cand, m_bot);
    if (w < 0) return -1;
    if (m_smm == 0) begin
      h = best(m_isr, m_bot);
      if (h >= 0 && rank_of(h, m_bot) <= rank_of(w, m_bot)) return -1;
    end
    return w;
  endfunction

  function automatic int exp_rdata();
    int w;
    if (a0) return m_imr;
    if (m_poll != 0) begin
      w = poll_winner();
      return (w >= 0) ? ('h80 | w) : 0;
    end
    return (m_sel != 0) ? m_isr : m_irr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_bot = 7;
      m_smm = 0; m_sel = 0; m_poll = 0; m_init2 = 0;
    end else begin
      int take, n_irr, h, lv;
      take = -1;
      if (rd && !a0 && m_poll != 0) take = poll_winner();
      n_irr = m_irr | int'(req);
      if (take >= 0) begin
        n_irr = n_irr & ~(1 << take);
        m_isr = m_isr | (1 << take);
      end
      if (rd && !a0) m_poll = 0;
      if (wr) begin
        lv = int'(wdata[2:0]);
        if (a0) begin
          if (m_init2 != 0) m_init2 = 0;
          else m_imr = int'(wdata);
        end else if (wdata[4]) begin
          m_isr = 0; m_imr = 0; m_bot = 7; m_smm = 0;
          m_sel = 0; m_poll = 0; m_init2 = 1; n_irr = 0;
        end else if (!wdata[3]) begin
          h = best(m_isr, m_bot);
          case (wdata[7:5])
            3'b001: if (h >= 0) m_isr = m_isr & ~(1 << h);
            3'b011: m_isr = m_isr & ~(1 << lv);
            3'b101: if (h >= 0) begin m_isr = m_isr & ~(1 << h); m_bot = h; end
            3'b111: begin m_isr = m_isr & ~(1 << lv); m_bot = lv; end
            3'b110: m_bot = lv;
            default: ;
          endcase
        end else begin
          if (wdata[2]) m_poll = 1;
          else if (wdata[1]) m_sel = int'(wdata[0]);
          if (wdata[6]) m_smm = int'(wdata[5]);
        end
      end
      m_irr = n_irr & 'hFF;
    end
  end

  // every-cycle comparison against the reference
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        n_checks++;
        if (rdata !== 8'(exp_rdata())) begin
          n_fail++;
          $display("FAIL %s model: rdata=%02h expected=%02h", cur_tag, rdata, 8'(exp_rdata()));
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmd(input logic addr, input logic [7:0] d);
    @(negedge clk);
    a0 = addr; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; a0 = 1'b0;
  endtask

  task automatic rd_chk(input logic addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    a0 = addr; rd = 1'b1;
    #(CLK_PERIOD/4 + 1);
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: a0=%0b rdata=%02h expected=%02h", tag, addr, rdata, exp);
    end
    @(negedge clk);
    rd = 1'b0; a0 = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
    req = '0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;

    cur_tag = "R1";
    rd_chk(1'b1, 8'h00, "R1 mask after reset");
    rd_chk(1'b0, 8'h00, "R1 pending after reset");

    cur_tag = "R3";
    wr_cmd(1'b1, 8'hA5);
    rd_chk(1'b1, 8'hA5, "R3 mask load");
    wr_cmd(1'b1, 8'h00);

    cur_tag = "R2";
    pulse_req(8'h12);
    rd_chk(1'b0, 8'h12, "R2 pending latched");
    idle(2);
    rd_chk(1'b0, 8'h12, "R2 pending held after input low");
    wr_cmd(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R2 in-service select");

    cur_tag = "R5";
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h81, "R5 poll returns line 1");
    rd_chk(1'b0, 8'h02, "R5 in-service bit set by poll");
    wr_cmd(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h10, "R5 pending bit cleared by poll");

    cur_tag = "R6";
    pulse_req(8'h01);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h80, "R6 higher line preempts in-service");
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h00, "R6 lower line blocked by in-service");
    cur_tag = "R10";
    wr_cmd(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h03, "R10 empty poll leaves in-service");
    wr_cmd(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h10, "R10 empty poll leaves pending");

    cur_tag = "R8";
    wr_cmd(1'b0, 8'h0B);
    wr_cmd(1'b0, 8'h20);
    rd_chk(1'b0, 8'h02, "R8 non-specific EOI clears line 0");
    wr_cmd(1'b0, 8'h61);
    rd_chk(1'b0, 8'h00, "R8 specific EOI clears line 1");

    cur_tag = "R5";
    wr_cmd(1'b1, 8'h10);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h00, "R5 masked line not reported");
    wr_cmd(1'b1, 8'h00);

    cur_tag = "R7";
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h84, "R7 setup take line 4");
    pulse_req(8'h40);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h00, "R7 normal mode blocks line 6");
    wr_cmd(1'b0, 8'h68);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h86, "R7 special mask lets line 6 through");
    wr_cmd(1'b0, 8'h48);
    rd_chk(1'b0, 8'h50, "R7 in-service after special mask take");

    cur_tag = "R9";
    wr_cmd(1'b0, 8'hC5);
    wr_cmd(1'b0, 8'h20);
    rd_chk(1'b0, 8'h10, "R9 bottom 5 makes line 6 highest in service");
    wr_cmd(1'b0, 8'hA0);
    rd_chk(1'b0, 8'h00, "R9 rotate on EOI clears line 4");
    pulse_req(8'h21);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h85, "R9 line 5 highest after rotation");
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h00, "R9 line 0 blocked by line 5");
    wr_cmd(1'b0, 8'hE5);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h80, "R9 rotate specific frees line 0");

    cur_tag = "R4";
    wr_cmd(1'b1, 8'h3C);
    wr_cmd(1'b0, 8'h13);
    wr_cmd(1'b1, 8'hFF);
    rd_chk(1'b1, 8'h00, "R4 mask cleared, second word ignored");
    rd_chk(1'b0, 8'h00, "R4 pending selected and cleared");
    wr_cmd(1'b1, 8'hF0);
    rd_chk(1'b1, 8'hF0, "R4 mask loads after init");
    pulse_req(8'h81);
    wr_cmd(1'b0, 8'h0C);
    rd_chk(1'b0, 8'h80, "R4 line 0 highest after init");
    wr_cmd(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h01, "R4 in-service after init poll");

    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule